// File: doc/BRIEF.md
# Two-Zone Address Encoder and Decoder

This block carries an address stream across a point-to-point bus of exactly the address width. It lowers how many bus lines toggle, and it adds no side wire for that purpose. Each end keeps two zone registers that follow where the stream currently is. The sending side compares each new address against both zones and puts a short signed offset from the nearer zone on the bus. The top bit of the bus word says which zone was used. The receiving side adds that offset to its own copy of the same zone. Both ends then apply one shared update rule, so their zone copies stay identical.

An address that is too far from both zones for the offset field is sent as an escape. The sender first puts a reserved offset code on the bus, then puts the raw address on the bus in the following cycle. While the raw word is going out, the sender stalls its input for that one cycle. The block contains both ends, and the encoded bus word between them is visible at the ports.

Top module: `zoneAddrCodec`

## Requirements
- R1: A synchronous reset clears both zone registers to zero on both sides and points the least-recently-used (LRU) marker at zone 0. Right after reset, `busValid` and `addrOutValid` are low and `addrReady` is high.
- R2: A direct bus word puts the zone index in bit ADDR_W-1. Bits ADDR_W-2:0 hold (address - zone) modulo 2^ADDR_W, truncated to two's complement in ADDR_W-1 bits.
- R3: The zone whose offset has the smaller magnitude is chosen. When the magnitudes are equal, zone 0 is chosen.
- R4: An address is sent directly only when the chosen offset lies within ±(2^(ADDR_W-2)-1). The offset code with only bit ADDR_W-2 set is never used for a direct word.
- R5: Any other address is escaped. The first word has bit ADDR_W-1 = 0 and bits ADDR_W-2:0 = 1 followed by zeros. The raw address follows in the next cycle, and during that cycle `addrReady` is low and any presented address is ignored.
- R6: After a direct word, the zone that was used holds the sent address, and the other zone becomes least recently used.
- R7: After an escape, the least recently used zone takes the raw address, and the LRU marker moves to the other zone.
- R8: The decoder emits every accepted address, in order, with `addrOutValid` one cycle after the word that completes it. A raw word is taken as an address even when its low bits match the reserved code.
- R9: A word appears on the bus, with `busValid` high, one cycle after the address is accepted. `busValid` is low when no word is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Address to send |
| addrValid | input | 1 | `addrIn` is presented this cycle |
| addrReady | output | 1 | Address is accepted this cycle when `addrValid` is high |
| busWord | output | ADDR_W | Encoded bus word (registered) |
| busValid | output | 1 | `busWord` carries a word this cycle |
| addrOut | output | ADDR_W | Reconstructed address |
| addrOutValid | output | 1 | `addrOut` is valid this cycle |

## Verification
Two events can fall in the same cycle: the second half of an escape and a new address arriving at the input. The bench provokes this by holding `addrValid` high with a different address while the raw word goes out. It then judges three things: that `addrReady` was low, that the raw word carried the escaped address, and that the decoded stream never contains the intruding value. A second overlap is a zone update together with the next zone choice: back-to-back addresses must be measured against the zone just overwritten. The bench covers this with every ordered pair of addresses in a 6-bit configuration. Each word is compared against an arithmetic model of the zones.

// File: rtl/zoneCodec_pkg.sv
package zoneCodec_pkg;

  // Strobes from the encoder control to the encoder datapath
  typedef struct packed {
    logic takeIn;     // address accepted this cycle
    logic sendDirect; // accepted address fits a zone offset
    logic sendMarker; // accepted address needs the escape pair
    logic sendRaw;    // second cycle of an escape
  } encStrb_t;

  // Zone table update request
  typedef struct packed {
    logic upd;    // write one zone this edge
    logic useLru; // write the least recently used zone
    logic sel;    // otherwise write this zone
  } zoneUpd_t;

endpackage

// File: rtl/zoneTable.sv
module zoneTable
  import zoneCodec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  zoneUpd_t               updIn,
  input  logic [ADDR_W-1:0]      loadVal,
  output logic [1:0][ADDR_W-1:0] zoneOut,
  output logic                   lruOut
);

  localparam int NUM_ZONES = 2;

  logic [ADDR_W-1:0] zoneQ [NUM_ZONES];
  logic              lruQ;
  logic              idx;

  assign idx = updIn.useLru ? lruQ : updIn.sel;

  for (genvar k = 0; k < NUM_ZONES; k++) begin : g_zone
    always_ff @(posedge clk) begin
      if (rst) zoneQ[k] <= '0;
      else if (updIn.upd && (idx == 1'(k))) zoneQ[k] <= loadVal;
    end
    assign zoneOut[k] = zoneQ[k];
  end

  always_ff @(posedge clk) begin
    if (rst) lruQ <= 1'b0;
    else if (updIn.upd) lruQ <= ~idx;
  end

  assign lruOut = lruQ;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (zoneQ[0] == '0 && zoneQ[1] == '0 && !lruQ)); // R1

endmodule

// File: rtl/zoneEncCtrl.sv
module zoneEncCtrl
  import zoneCodec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     addrValid,
  input  logic     needEsc,
  output logic     addrReady,
  output encStrb_t strb
);

  typedef enum logic {ENC_IDLE, ENC_RAW} encState_t;

  encState_t state, stateNext;
  logic      accept;

  assign addrReady = (state == ENC_IDLE);
  assign accept    = addrValid && addrReady;

  always_comb begin
    strb.takeIn     = accept;
    strb.sendDirect = accept && !needEsc;
    strb.sendMarker = accept && needEsc;
    strb.sendRaw    = (state == ENC_RAW);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ENC_IDLE: if (accept && needEsc) stateNext = ENC_RAW;
      ENC_RAW:  stateNext = ENC_IDLE;
      default:  stateNext = ENC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ENC_IDLE;
    else     state <= stateNext;
  end

  AST_ESC_STALLS_ONCE: assert property (@(posedge clk) disable iff (rst)
    strb.sendMarker |=> (!addrReady && strb.sendRaw) ##1 addrReady); // R5

endmodule

// File: rtl/zoneEncPath.sv
module zoneEncPath
  import zoneCodec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addrIn,
  input  encStrb_t               strb,
  input  logic [1:0][ADDR_W-1:0] zoneIn,
  output logic                   needEsc,
  output logic [ADDR_W-1:0]      busWord,
  output logic                   busValid,
  output zoneUpd_t               updOut,
  output logic [ADDR_W-1:0]      loadVal
);

  localparam int OFF_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] OFF_LIM = ADDR_W'((1 << (ADDR_W - 2)) - 1);
  localparam logic [OFF_W-1:0]  MARKER_OFF = {1'b1, {(OFF_W-1){1'b0}}};

  logic [ADDR_W-1:0] diffZ [2];
  logic [ADDR_W-1:0] magZ  [2];
  logic              pick1;
  logic [ADDR_W-1:0] diffSel;
  logic [ADDR_W-1:0] magSel;
  logic [ADDR_W-1:0] escAddr;

  for (genvar k = 0; k < 2; k++) begin : g_off
    assign diffZ[k] = addrIn - zoneIn[k];
    assign magZ[k]  = diffZ[k][ADDR_W-1] ? ('0 - diffZ[k]) : diffZ[k];
  end

  assign pick1   = (magZ[1] < magZ[0]);
  assign diffSel = pick1 ? diffZ[1] : diffZ[0];
  assign magSel  = pick1 ? magZ[1] : magZ[0];
  assign needEsc = (magSel > OFF_LIM);

  always_ff @(posedge clk) begin
    if (rst) escAddr <= '0;
    else if (strb.sendMarker) escAddr <= addrIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busWord  <= '0;
      busValid <= 1'b0;
    end else begin
      busValid <= strb.sendDirect || strb.sendMarker || strb.sendRaw;
      if (strb.sendDirect)      busWord <= {pick1, diffSel[OFF_W-1:0]};
      else if (strb.sendMarker) busWord <= {1'b0, MARKER_OFF};
      else if (strb.sendRaw)    busWord <= escAddr;
    end
  end

  always_comb begin
    updOut.upd    = strb.sendDirect || strb.sendRaw;
    updOut.useLru = strb.sendRaw;
    updOut.sel    = pick1;
    loadVal       = strb.sendRaw ? escAddr : addrIn;
  end

  AST_ACCEPT_TO_WORD: assert property (@(posedge clk) disable iff (rst)
    strb.takeIn |=> busValid); // R9

  AST_DIRECT_NOT_MARKER: assert property (@(posedge clk) disable iff (rst)
    strb.sendDirect |=> (busWord[OFF_W-1:0] != MARKER_OFF)); // R4

endmodule

// File: rtl/zoneDecoder.sv
module zoneDecoder
  import zoneCodec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      busWord,
  input  logic                   busValid,
  input  logic [1:0][ADDR_W-1:0] zoneIn,
  output zoneUpd_t               updOut,
  output logic [ADDR_W-1:0]      loadVal,
  output logic [ADDR_W-1:0]      addrOut,
  output logic                   addrOutValid
);

  localparam int OFF_W = ADDR_W - 1;
  localparam logic [OFF_W-1:0] MARKER_OFF = {1'b1, {(OFF_W-1){1'b0}}};

  logic              waitRaw;
  logic              isMarker;
  logic [ADDR_W-1:0] zoneSel;
  logic [ADDR_W-1:0] recon;

  assign isMarker = (busWord[OFF_W-1:0] == MARKER_OFF);
  assign zoneSel  = busWord[ADDR_W-1] ? zoneIn[1] : zoneIn[0];
  assign recon    = zoneSel + {busWord[OFF_W-1], busWord[OFF_W-1:0]};

  always_comb begin
    updOut.upd    = busValid && (waitRaw || !isMarker);
    updOut.useLru = waitRaw;
    updOut.sel    = busWord[ADDR_W-1];
    loadVal       = waitRaw ? busWord : recon;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitRaw      <= 1'b0;
      addrOut      <= '0;
      addrOutValid <= 1'b0;
    end else begin
      addrOutValid <= updOut.upd;
      if (updOut.upd) addrOut <= loadVal;
      if (busValid) waitRaw <= !waitRaw && isMarker;
    end
  end

  AST_RAW_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (busValid && waitRaw) |=> (addrOutValid && !waitRaw)); // R8

endmodule

// File: rtl/zoneAddrCodec.sv
module zoneAddrCodec
  import zoneCodec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrValid,
  output logic              addrReady,
  output logic [ADDR_W-1:0] busWord,
  output logic              busValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOutValid
);

  encStrb_t              strb;
  logic                  needEsc;
  zoneUpd_t              encUpd, decUpd;
  logic [ADDR_W-1:0]     encLoad, decLoad;
  logic [1:0][ADDR_W-1:0] encZones, decZones;
  logic                  encLru, decLru;

  zoneEncCtrl u_encCtrl (
    .clk(clk), .rst(rst), .addrValid(addrValid), .needEsc(needEsc),
    .addrReady(addrReady), .strb(strb)
  );

  zoneEncPath #(.ADDR_W(ADDR_W)) u_encPath (
    .clk(clk), .rst(rst), .addrIn(addrIn), .strb(strb), .zoneIn(encZones),
    .needEsc(needEsc), .busWord(busWord), .busValid(busValid),
    .updOut(encUpd), .loadVal(encLoad)
  );

  zoneTable #(.ADDR_W(ADDR_W)) u_encTable (
    .clk(clk), .rst(rst), .updIn(encUpd), .loadVal(encLoad),
    .zoneOut(encZones), .lruOut(encLru)
  );

  zoneDecoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .busWord(busWord), .busValid(busValid),
    .zoneIn(decZones), .updOut(decUpd), .loadVal(decLoad),
    .addrOut(addrOut), .addrOutValid(addrOutValid)
  );

  zoneTable #(.ADDR_W(ADDR_W)) u_decTable (
    .clk(clk), .rst(rst), .updIn(decUpd), .loadVal(decLoad),
    .zoneOut(decZones), .lruOut(decLru)
  );

  AST_TABLES_IN_STEP: assert property (@(posedge clk) disable iff (rst || $past(rst))
    (decZones == $past(encZones)) && (decLru == $past(encLru))); // R6 R7

endmodule

// File: tb/sim_zoneAddrCodec.sv
module sim_zoneAddrCodec;

  localparam int W   = 6;
  localparam int MOD = 1 << W;
  localparam int LIM = (1 << (W - 2)) - 1;
  localparam int MARKER = 1 << (W - 2);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] addrIn = '0;
  logic         addrValid = 1'b0;
  logic         addrReady;
  logic [W-1:0] busWord;
  logic         busValid;
  logic [W-1:0] addrOut;
  logic         addrOutValid;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  int mZone [2];
  int mLru;

  logic [W-1:0] expQ [64];
  int wrP = 0;
  int rdP = 0;

  always #2 clk = ~clk;

  zoneAddrCodec #(.ADDR_W(W)) u0 (
    .clk(clk), .rst(rst), .addrIn(addrIn), .addrValid(addrValid),
    .addrReady(addrReady), .busWord(busWord), .busValid(busValid),
    .addrOut(addrOut), .addrOutValid(addrOutValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wrapDiff(input int a, input int z);
    int d = a - z;
    if (d >= MOD / 2) d -= MOD;
    else if (d < -(MOD / 2)) d += MOD;
    return d;
  endfunction

  function automatic int absInt(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic resetModel();
    mZone[0] = 0;
    mZone[1] = 0;
    mLru = 0;
  endtask

  // Called at a negedge; returns at a negedge
  task automatic sendAddr(input int a);
    int d0, d1, m0, m1, sel, ds, ms, exp;
    d0 = wrapDiff(a, mZone[0]);
    d1 = wrapDiff(a, mZone[1]);
    m0 = absInt(d0);
    m1 = absInt(d1);
    sel = (m1 < m0) ? 1 : 0;               // R3 tie goes to zone 0
    ds = sel ? d1 : d0;
    ms = sel ? m1 : m0;
    check(addrReady === 1'b1, "R5 ready before send", int'(addrReady), 1);
    addrIn = W'(a);
    addrValid = 1'b1;
    @(negedge clk);
    if (ms <= LIM) begin
      exp = sel * (MOD / 2) + (ds & (MOD / 2 - 1));
      check(busValid === 1'b1 && int'(busWord) == exp, "R2 R3 R4 R6 R7 R9 direct word",
            int'(busWord), exp);
      mZone[sel] = a;
      mLru = 1 - sel;
      addrValid = 1'b0;
    end else begin
      check(busValid === 1'b1 && int'(busWord) == MARKER, "R4 R5 escape marker",
            int'(busWord), MARKER);
      check(addrReady === 1'b0, "R5 stall during raw", int'(addrReady), 0);
      addrIn = W'(a ^ 42);                  // intruder, must be ignored
      addrValid = 1'b1;
      @(negedge clk);
      check(busValid === 1'b1 && int'(busWord) == a, "R5 raw word", int'(busWord), a);
      mZone[mLru] = a;                      // R7
      mLru = 1 - mLru;
      addrValid = 1'b0;
    end
    expQ[wrP % 64] = W'(a);
    wrP++;
  endtask

  // Decoder monitor: R8 order and content
  always @(negedge clk) begin
    if (!rst && addrOutValid === 1'b1) begin
      if (rdP == wrP) begin
        check(1'b0, "R8 spurious decode", int'(addrOut), -1);
      end else begin
        check(addrOut == expQ[rdP % 64], "R8 decoded address",
              int'(addrOut), int'(expQ[rdP % 64]));
        rdP++;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check(busValid === 1'b0, "R1 busValid after reset", int'(busValid), 0);
    check(addrOutValid === 1'b0, "R1 addrOutValid after reset", int'(addrOutValid), 0);
    check(addrReady === 1'b1, "R1 addrReady after reset", int'(addrReady), 1);

    // R1: zeroed zones give offset = address for a small first address
    sendAddr(5);
    // R8 latency: decode one cycle after the direct word
    @(negedge clk);
    check(addrOutValid === 1'b1 && addrOut == W'(5), "R8 decode latency", int'(addrOut), 5);
    // R9: idle bus
    check(busValid === 1'b0, "R9 idle bus", int'(busValid), 0);

    // R4 boundary: exactly LIM away, then LIM+1 away
    sendAddr(5 + LIM);
    sendAddr(5 + LIM + LIM + 1);

    // Ascending sweep with wrap
    for (int a = 0; a < MOD; a++) sendAddr(a);
    sendAddr(0);

    // Interleaved zones
    for (int i = 0; i < 20; i++) begin
      sendAddr(8 + i);
      sendAddr(40 + i);
    end

    // Every ordered pair
    for (int a = 0; a < MOD; a++) begin
      for (int b = 0; b < MOD; b++) begin
        sendAddr(a);
        sendAddr(b);
      end
    end

    // Mid-run reset: R1
    idle(3);
    check(rdP == wrP, "R8 all decoded", rdP, wrP);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    resetModel();
    rdP = wrP;
    check(busValid === 1'b0 && addrReady === 1'b1, "R1 state after mid-run reset",
          int'(busValid), 0);
    sendAddr(MOD - 3);   // -3 from zero zones: direct
    sendAddr(MOD / 2);   // far: escape
    idle(3);
    check(rdP == wrP, "R8 final drain", rdP, wrP);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R8: actual %0d expected %0d", rdP, wrP);
      summary();
      $finish;
    end
  end

endmodule